// File: doc/BRIEF.md
# Unified Translation Lookaside Buffer with Replace Counter

This block translates 32-bit virtual addresses into physical addresses for a processor core. Its 64-entry fully associative array holds pages of four sizes side by side. Every access is first checked against the fixed windows of the address space that bypass translation. If translation is on, the access is then matched against the array by virtual page number and address-space identifier. The block returns the physical address and read, write and execute permissions in the same cycle. A fault code in the core's exception numbering appears one clock later.

Software fills the array with a load command. The command takes a page-table-entry high word (virtual page and identifier) and a low word (physical page, size, protection and attribute bits). It writes them into the slot named by a replace counter. The counter steps on every access that goes to the array. It wraps to zero after a programmable bound, or after the last slot when the bound is zero. Overwriting a valid slot raises a one-cycle page-flush request that carries the old page's address. A single invalidate pulse empties the whole array.

Top module: `utlb_xlate`

## Requirements
- R1: Virtual addresses 0x80000000..0xBFFFFFFF translate to the address ANDed with 0x1FFFFFFF, and addresses at or above 0xE0000000 translate unchanged. In privileged mode both windows give fault 0x000 with all three permissions set, and they never step the replace counter.
- R2: In user mode, an access to those windows outside 0xE0000000..0xE3FFFFFF is an address error: code 0x0E0 for a read or fetch (acc_kind 0 or 2), 0x100 for a write (acc_kind 1). The range 0xE0000000..0xE3FFFFFF stays usable from user mode.
- R3: With xlate_en low, every address outside the R1 windows maps to the address ANDed with 0x1FFFFFFF, with all permissions and no fault.
- R4: An entry's identifier must equal cur_asid unless the entry's shared bit is set, or the access is privileged with shared_sv high.
- R5: The size code selects the page size: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB, 3 is 1 MB. The physical address is the physical page base (page number << 10, truncated to the page size) ORed with the in-page offset of the virtual address.
- R6: The replace counter urc steps by one on each valid access that reaches the array (xlate_en high, outside the R1 windows). It returns to 0 when the stepped value would exceed a nonzero wrap_bound, or would exceed 63.
- R7: Fault codes are checked in this order: multiple hit 0x140; miss 0x040 on read or fetch, 0x060 on write; user access to an entry whose protection bit 1 is clear gives 0x0A0 on read, 0x0C0 on write; a write with protection bit 0 clear gives 0x0C0; a write to an entry whose dirty bit is clear gives 0x080.
- R8: On an array hit, read and execute are granted and write is granted only when protection bit 0 and the dirty bit are both set. All permissions are low whenever the access faults.
- R9: load_req writes the slot indexed by urc. From pteh it takes VPN = pteh[31:10] and identifier = pteh[7:0]. From ptel it takes PPN = ptel[28:10], valid = ptel[8], size = ptel[7:6], protection = ptel[5:4], cacheable = ptel[3], dirty = ptel[2], shared = ptel[1], write-through = ptel[0]. If the slot was valid, flush_req pulses on the next cycle with flush_va = old VPN << 10; otherwise it stays low.
- R10: A cycle with inval_all high clears every valid bit, so that no later lookup hits until reloaded.
- R11: pa and the permissions follow the inputs in the same cycle. fault_code shows the access's code on the clock after it is presented, and 0x000 after a cycle with no access.
- R12: After reset urc is 0, fault_code is 0x000, flush_req is low and every slot is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_va | input | 32 | Virtual address |
| priv_mode | input | 1 | Core is in privileged mode |
| xlate_en | input | 1 | Address translation enabled |
| shared_sv | input | 1 | Privileged accesses ignore identifiers |
| cur_asid | input | 8 | Current address-space identifier |
| wrap_bound | input | 6 | Replace-counter wrap bound (0 means full range) |
| load_req | input | 1 | Load one entry at the replace counter |
| pteh | input | 32 | Entry high word: VPN and identifier |
| ptel | input | 32 | Entry low word: PPN, valid, size, protection, attributes |
| inval_all | input | 1 | Clear every valid bit |
| pa | output | 32 | Physical address |
| perm_r | output | 1 | Read permitted |
| perm_w | output | 1 | Write permitted |
| perm_x | output | 1 | Execute permitted |
| fault_code | output | 12 | Registered fault code, 0 when none |
| urc | output | 6 | Replace counter |
| flush_req | output | 1 | Overwritten valid page must be flushed |
| flush_va | output | 32 | Virtual base of the page to flush |

## Verification
Translations are tried on pages of each of the four sizes, with offsets that reach above the 1 KB boundary. These show whether the size mask is applied on both the compare and the address merge. Accesses are repeated with matching and differing identifiers, with shared and non-shared entries, and in user and privileged mode with the supervisor-share option on and off, which isolates each term of the identifier rule. Read, write and fetch are run against entries with each protection and dirty combination, and against two overlapping entries. This separates every fault code and its priority. Addresses just inside and outside the user store window and the untranslated windows, along with counter runs at a small and a zero wrap bound, cover the edges of decode and replacement.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

   localparam int ASID_W = 8;
   localparam int VPN_W  = 22;
   localparam int PPN_W  = 19;
   localparam int FC_W   = 12;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_kind_e;

   typedef struct packed {
      logic              valid;
      logic [VPN_W-1:0]  vpn;
      logic [ASID_W-1:0] asid;
      logic [PPN_W-1:0]  ppn;
      logic [1:0]        sz;
      logic              sh;
      logic              cache;
      logic [1:0]        pr;
      logic              dirty;
      logic              wthru;
   } tlb_ent_t;

   localparam logic [FC_W-1:0] FC_NONE    = 12'h000;
   localparam logic [FC_W-1:0] FC_RD_MISS = 12'h040;
   localparam logic [FC_W-1:0] FC_WR_MISS = 12'h060;
   localparam logic [FC_W-1:0] FC_INIT_WR = 12'h080;
   localparam logic [FC_W-1:0] FC_RD_PROT = 12'h0A0;
   localparam logic [FC_W-1:0] FC_WR_PROT = 12'h0C0;
   localparam logic [FC_W-1:0] FC_RD_ADDR = 12'h0E0;
   localparam logic [FC_W-1:0] FC_WR_ADDR = 12'h100;
   localparam logic [FC_W-1:0] FC_MULTI   = 12'h140;

   // Mask over VPN bits that take part in the page compare
   function automatic logic [VPN_W-1:0] page_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    page_mask = {VPN_W{1'b1}};
         2'd1:    page_mask = {{(VPN_W-2){1'b1}}, 2'b00};
         2'd2:    page_mask = {{(VPN_W-6){1'b1}}, 6'b0};
         default: page_mask = {{(VPN_W-10){1'b1}}, 10'b0};
      endcase
   endfunction

endpackage

// File: rtl/utlb_region_dec.sv
module utlb_region_dec
   import utlb_pkg::*;
(
   input  logic [31:0] va,
   input  logic        priv,
   input  logic        xlate_on,
   output logic        fixed_win,
   output logic        addr_err,
   output logic        use_array,
   output logic [31:0] pa_direct
);
   logic mid_win;
   logic top_win;
   logic user_ok;

   assign mid_win   = (va[31:30] == 2'b10);
   assign top_win   = (va[31:29] == 3'b111);
   assign user_ok   = (va[31:26] == 6'b111000);
   assign fixed_win = mid_win | top_win;
   assign addr_err  = fixed_win & ~priv & ~user_ok;
   assign use_array = ~fixed_win & xlate_on;
   assign pa_direct = top_win ? va : {3'b000, va[28:0]};

endmodule

// File: rtl/utlb_urc.sv
module utlb_urc #(
   parameter int ENTRIES = 64,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [IDX_W-1:0] bound,
   output logic [IDX_W-1:0] urc_q
);
   localparam logic [IDX_W:0] LAST = (IDX_W+1)'(ENTRIES - 1);

   logic [IDX_W:0] bumped;
   logic           wrap;

   assign bumped = {1'b0, urc_q} + 1'b1;
   assign wrap   = ((bound != '0) && (bumped > {1'b0, bound})) || (bumped > LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    urc_q <= '0;
      else if (step) urc_q <= wrap ? '0 : bumped[IDX_W-1:0];
   end

   // R6
   urc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && bound != '0 && urc_q == bound) |=> (urc_q == '0));

   // R6
   urc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(urc_q));

endmodule

// File: rtl/utlb_array.sv
module utlb_array
   import utlb_pkg::*;
#(
   parameter int ENTRIES = 64,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inval,
   input  logic              ld_en,
   input  logic [IDX_W-1:0]  ld_idx,
   input  tlb_ent_t          ld_ent,
   input  logic [VPN_W-1:0]  look_vpn,
   input  logic [ASID_W-1:0] look_asid,
   input  logic              asid_chk,
   output logic              hit,
   output logic              multi,
   output tlb_ent_t          hit_ent,
   output logic              flush_q,
   output logic [31:0]       flush_va_q
);
   logic [ENTRIES-1:0] valid_vec;
   logic [ENTRIES-1:0] match_vec;
   tlb_ent_t           part [ENTRIES];
   logic [VPN_W-1:0]   vpn_arr [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      tlb_ent_t         ent_q;
      logic [VPN_W-1:0] msk;
      logic             id_ok;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 ent_q <= '0;
         else if (inval)                             ent_q.valid <= 1'b0;
         else if (ld_en && ld_idx == IDX_W'(g))      ent_q <= ld_ent;
      end

      assign msk          = page_mask(ent_q.sz);
      assign id_ok        = ent_q.sh | ~asid_chk | (ent_q.asid == look_asid);
      assign match_vec[g] = ent_q.valid & id_ok & ((look_vpn & msk) == (ent_q.vpn & msk));
      assign valid_vec[g] = ent_q.valid;
      assign vpn_arr[g]   = ent_q.vpn;
      assign part[g]      = match_vec[g] ? ent_q : '0;
   end

   always_comb begin
      hit_ent = '0;
      for (int i = 0; i < ENTRIES; i++) hit_ent = hit_ent | part[i];
   end

   assign hit   = |match_vec;
   assign multi = (match_vec & (match_vec - 1'b1)) != '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_q    <= 1'b0;
         flush_va_q <= '0;
      end else begin
         flush_q    <= ld_en & ~inval & valid_vec[ld_idx];
         flush_va_q <= {vpn_arr[ld_idx], 10'b0};
      end
   end

   // R10
   inval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inval |=> (valid_vec == '0));

   // R9
   load_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !inval && valid_vec[ld_idx]) |=> flush_q);

   // R9
   load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !inval) |=> (valid_vec[$past(ld_idx)] == $past(ld_ent.valid)));

endmodule

// File: rtl/utlb_check.sv
module utlb_check
   import utlb_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_valid,
   input  logic [1:0]      kind,
   input  logic            priv,
   input  logic            addr_err,
   input  logic            use_array,
   input  logic            hit,
   input  logic            multi,
   input  logic [1:0]      pr,
   input  logic            dirty,
   output logic [FC_W-1:0] code_now,
   output logic [FC_W-1:0] fault_q
);
   logic is_wr;
   assign is_wr = (kind == ACC_WRITE);

   always_comb begin
      if (addr_err)                code_now = is_wr ? FC_WR_ADDR : FC_RD_ADDR;
      else if (!use_array)         code_now = FC_NONE;
      else if (multi)              code_now = FC_MULTI;
      else if (!hit)               code_now = is_wr ? FC_WR_MISS : FC_RD_MISS;
      else if (!priv && !pr[1])    code_now = is_wr ? FC_WR_PROT : FC_RD_PROT;
      else if (is_wr && !pr[0])    code_now = FC_WR_PROT;
      else if (is_wr && !dirty)    code_now = FC_INIT_WR;
      else                         code_now = FC_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fault_q <= FC_NONE;
      else        fault_q <= acc_valid ? code_now : FC_NONE;
   end

   // R11
   fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q != FC_NONE) |-> $past(acc_valid));

   // R7
   multi_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && use_array && !addr_err && multi) |=> (fault_q == FC_MULTI));

endmodule

// File: rtl/utlb_xlate.sv
module utlb_xlate
   import utlb_pkg::*;
#(
   parameter int ENTRIES = 64,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [1:0]        acc_kind,
   input  logic [31:0]       acc_va,
   input  logic              priv_mode,
   input  logic              xlate_en,
   input  logic              shared_sv,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic [IDX_W-1:0]  wrap_bound,
   input  logic              load_req,
   input  logic [31:0]       pteh,
   input  logic [31:0]       ptel,
   input  logic              inval_all,
   output logic [31:0]       pa,
   output logic              perm_r,
   output logic              perm_w,
   output logic              perm_x,
   output logic [FC_W-1:0]   fault_code,
   output logic [IDX_W-1:0]  urc,
   output logic              flush_req,
   output logic [31:0]       flush_va
);
   initial begin
      if (ENTRIES < 2 || ENTRIES > 64)
         $fatal(1, "utlb_xlate: ENTRIES must lie in 2..64");
   end

   logic            fixed_win, addr_err, use_array;
   logic [31:0]     pa_direct, pa_tlb, page_bits;
   logic            hit, multi, ok;
   tlb_ent_t        hit_ent, ld_ent;
   logic [FC_W-1:0] code_now;
   logic            unused_bits;

   utlb_region_dec u_region (
      .va        (acc_va),
      .priv      (priv_mode),
      .xlate_on  (xlate_en),
      .fixed_win (fixed_win),
      .addr_err  (addr_err),
      .use_array (use_array),
      .pa_direct (pa_direct)
   );

   utlb_urc #(.ENTRIES(ENTRIES)) u_urc (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (acc_valid & use_array),
      .bound (wrap_bound),
      .urc_q (urc)
   );

   always_comb begin
      ld_ent       = '0;
      ld_ent.vpn   = pteh[31:10];
      ld_ent.asid  = pteh[ASID_W-1:0];
      ld_ent.ppn   = ptel[28:10];
      ld_ent.valid = ptel[8];
      ld_ent.sz    = ptel[7:6];
      ld_ent.pr    = ptel[5:4];
      ld_ent.cache = ptel[3];
      ld_ent.dirty = ptel[2];
      ld_ent.sh    = ptel[1];
      ld_ent.wthru = ptel[0];
   end

   utlb_array #(.ENTRIES(ENTRIES)) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .inval      (inval_all),
      .ld_en      (load_req),
      .ld_idx     (urc),
      .ld_ent     (ld_ent),
      .look_vpn   (acc_va[31:10]),
      .look_asid  (cur_asid),
      .asid_chk   (~shared_sv | ~priv_mode),
      .hit        (hit),
      .multi      (multi),
      .hit_ent    (hit_ent),
      .flush_q    (flush_req),
      .flush_va_q (flush_va)
   );

   utlb_check u_check (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .kind      (acc_kind),
      .priv      (priv_mode),
      .addr_err  (addr_err),
      .use_array (use_array),
      .hit       (hit),
      .multi     (multi),
      .pr        (hit_ent.pr),
      .dirty     (hit_ent.dirty),
      .code_now  (code_now),
      .fault_q   (fault_code)
   );

   assign page_bits = {page_mask(hit_ent.sz), 10'b0};
   assign pa_tlb    = ({3'b000, hit_ent.ppn, 10'b0} & page_bits) | (acc_va & ~page_bits);
   assign pa        = use_array ? pa_tlb : pa_direct;

   assign ok     = (code_now == FC_NONE);
   assign perm_r = ok;
   assign perm_x = ok;
   assign perm_w = ok & (use_array ? (hit_ent.pr[0] & hit_ent.dirty) : 1'b1);

   assign unused_bits = ^{pteh[9:8], pteh[31:10] & 22'h0, ptel[31:29], ptel[9],
                          hit_ent.valid, hit_ent.vpn, hit_ent.asid, hit_ent.sh,
                          hit_ent.cache, hit_ent.wthru};

   // R1
   fixed_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && fixed_win && priv_mode) |=> (fault_code == FC_NONE));

   // R2
   user_wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && fixed_win && !priv_mode && acc_va[31:26] != 6'b111000
       && acc_kind == 2'd1) |=> (fault_code == FC_WR_ADDR));

endmodule

// File: tb/utlb_xlate_bench.sv
module utlb_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [1:0]  acc_kind = 2'd0;
   logic [31:0] acc_va = '0;
   logic        priv_mode = 1'b0;
   logic        xlate_en = 1'b1;
   logic        shared_sv = 1'b0;
   logic [7:0]  cur_asid = 8'h05;
   logic [5:0]  wrap_bound = 6'd0;
   logic        load_req = 1'b0;
   logic [31:0] pteh = '0;
   logic [31:0] ptel = '0;
   logic        inval_all = 1'b0;
   logic [31:0] pa, flush_va;
   logic        perm_r, perm_w, perm_x, flush_req;
   logic [11:0] fault_code;
   logic [5:0]  urc;

   int nchk = 0;
   int nerr = 0;
   int exp_urc = 0;

   always #5 clk = ~clk;

   utlb_xlate u_utlb_xlate (
      .clk, .rst_n, .acc_valid, .acc_kind, .acc_va, .priv_mode, .xlate_en,
      .shared_sv, .cur_asid, .wrap_bound, .load_req, .pteh, .ptel, .inval_all,
      .pa, .perm_r, .perm_w, .perm_x, .fault_code, .urc, .flush_req, .flush_va
   );

   // {va, pa, fault, asid, kind, priv, sv, at, exp_w, req}
   localparam int NV = 25;
   localparam logic [95:0] VEC [NV] = '{
      {32'h00400123, 32'h01000123, 12'h000, 8'h05, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd5},  // R5 1K
      {32'h00400123, 32'h01000123, 12'h000, 8'h05, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd8},  // R8
      {32'h00500ABC, 32'h02000ABC, 12'h000, 8'h05, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 6'd5},  // R5 4K
      {32'h00500ABC, 32'h0,        12'h080, 8'h05, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 6'd7},  // R7 clean
      {32'h00500ABC, 32'h0,        12'h0A0, 8'h05, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd7},  // R7 user rd
      {32'h00500ABC, 32'h0,        12'h0C0, 8'h05, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd7},  // R7 user wr
      {32'h0060F123, 32'h0300F123, 12'h000, 8'h05, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd5},  // R5 64K
      {32'h0060F123, 32'h0,        12'h0C0, 8'h05, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd7},  // R7 pr0
      {32'h100ABCDE, 32'h040ABCDE, 12'h000, 8'h05, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd4},  // R4 shared 1M
      {32'h00700010, 32'h0,        12'h040, 8'h05, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd4},  // R4 asid miss
      {32'h00700010, 32'h0,        12'h060, 8'h05, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd7},  // R7 wr miss
      {32'h00700010, 32'h05000010, 12'h000, 8'h05, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 6'd4},  // R4 sv
      {32'h00700010, 32'h0,        12'h040, 8'h05, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 6'd4},  // R4 no sv
      {32'h00800004, 32'h0,        12'h140, 8'h05, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 6'd7},  // R7 multi
      {32'h8ABCDEF0, 32'h0ABCDEF0, 12'h000, 8'h05, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 6'd1},  // R1
      {32'hE1234567, 32'hE1234567, 12'h000, 8'h05, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd1},  // R1
      {32'hA0000010, 32'h0,        12'h0E0, 8'h05, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd2},  // R2
      {32'hF0000000, 32'h0,        12'h100, 8'h05, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd2},  // R2
      {32'hE4000000, 32'h0,        12'h100, 8'h05, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 6'd2},  // R2 edge
      {32'hE3FFFFFC, 32'hE3FFFFFC, 12'h000, 8'h05, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 6'd2},  // R2 edge
      {32'h00400123, 32'h00400123, 12'h000, 8'h05, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 6'd3},  // R3
      {32'hF0000000, 32'h0,        12'h0E0, 8'h05, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 6'd2},  // R2 fetch
      {32'h00400123, 32'h01000123, 12'h000, 8'h05, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 6'd5},  // R5 fetch
      {32'h00400123, 32'h0,        12'h040, 8'h06, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd4},  // R4 id
      {32'hC0001234, 32'h00001234, 12'h000, 8'h05, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 6'd3}   // R3
   };

   task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL R%0d %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic int next_urc(input int u, input int b);
      int n = u + 1;
      if ((b != 0 && n > b) || n > 63) n = 0;
      return n;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; acc_valid = 1'b0; load_req = 1'b0; inval_all = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      exp_urc = 0;
   endtask

   task automatic do_acc(input logic [31:0] va, input logic [1:0] kind, input logic priv,
                         input logic sv, input logic at, input logic [7:0] asid, input logic chk_on,
                         input logic [31:0] exp_pa, input logic [11:0] exp_fc, input logic exp_w,
                         input int req);
      logic fixed;
      @(negedge clk);
      acc_valid = 1'b1; acc_va = va; acc_kind = kind; priv_mode = priv;
      shared_sv = sv; xlate_en = at; cur_asid = asid;
      #1;
      if (chk_on) begin
         if (exp_fc == 12'h000) chk(req, "pa", pa, exp_pa);
         chk(req == 5 ? 8 : req, "perm_w", {31'b0, perm_w}, {31'b0, exp_w});
      end
      @(posedge clk);
      #1;
      acc_valid = 1'b0;
      fixed = (va[31:30] == 2'b10) || (va[31:29] == 3'b111);
      if (at && !fixed) exp_urc = next_urc(exp_urc, int'(wrap_bound));
      if (chk_on) chk(req, "fault_code", {20'b0, fault_code}, {20'b0, exp_fc});
      chk(6, "urc", {26'b0, urc}, exp_urc[31:0]);
   endtask

   task automatic do_load(input logic [31:0] va, input logic [7:0] asid, input logic [31:0] pbase,
                          input logic [1:0] sz, input logic [1:0] pr, input logic d, input logic sh);
      @(negedge clk);
      load_req = 1'b1;
      pteh = {va[31:10], 2'b00, asid};
      ptel = {3'b000, pbase[28:10], 1'b0, 1'b1, sz, pr, 1'b1, d, sh, 1'b0};
      @(posedge clk);
      #1;
      load_req = 1'b0;
   endtask

   task automatic dummy();
      do_acc(32'h7FF00000, 2'd0, 1'b1, 1'b0, 1'b1, 8'h05, 1'b0, 32'h0, 12'h0, 1'b0, 6);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      do_reset();
      // R12 reset state
      chk(12, "urc reset", {26'b0, urc}, 32'd0);
      chk(12, "fault reset", {20'b0, fault_code}, 32'd0);
      chk(12, "flush reset", {31'b0, flush_req}, 32'd0);
      do_acc(32'h00400123, 2'd0, 1'b1, 1'b0, 1'b1, 8'h05, 1'b1, 32'h0, 12'h040, 1'b0, 12);

      do_load(32'h00400000, 8'h05, 32'h01000000, 2'd0, 2'b11, 1'b1, 1'b0); dummy();
      do_load(32'h00500000, 8'h05, 32'h02000000, 2'd1, 2'b01, 1'b0, 1'b0); dummy();
      do_load(32'h00600000, 8'h05, 32'h03000000, 2'd2, 2'b10, 1'b1, 1'b0); dummy();
      do_load(32'h10000000, 8'h09, 32'h04000000, 2'd3, 2'b11, 1'b1, 1'b1); dummy();
      do_load(32'h00700000, 8'h07, 32'h05000000, 2'd0, 2'b11, 1'b1, 1'b0); dummy();
      do_load(32'h00800000, 8'h05, 32'h06000000, 2'd0, 2'b11, 1'b1, 1'b0); dummy();
      do_load(32'h00800000, 8'h05, 32'h07000000, 2'd1, 2'b11, 1'b1, 1'b0); dummy();

      for (int i = 0; i < NV; i++) begin
         logic [95:0] v;
         v = VEC[i];
         do_acc(v[95:64], v[11:10], v[9], v[8], v[7], v[19:12], 1'b1,
                v[63:32], v[31:20], v[6], int'(v[5:0]));
      end

      // R11: no access leaves fault_code at zero
      @(negedge clk);
      @(posedge clk); #1;
      chk(11, "fault idle", {20'b0, fault_code}, 32'd0);

      // R9: reload of a valid slot requests a flush of the old page
      do_reset();
      do_load(32'h00400000, 8'h05, 32'h01000000, 2'd0, 2'b11, 1'b1, 1'b0);
      chk(9, "flush first load", {31'b0, flush_req}, 32'd0);
      do_load(32'h00900000, 8'h05, 32'h01000000, 2'd0, 2'b11, 1'b1, 1'b0);
      chk(9, "flush reload", {31'b0, flush_req}, 32'd1);
      chk(9, "flush va", flush_va, 32'h00400000);
      do_acc(32'h00900010, 2'd0, 1'b1, 1'b0, 1'b1, 8'h05, 1'b1, 32'h01000010, 12'h000, 1'b1, 9);

      // R10: invalidate empties the array
      @(negedge clk); inval_all = 1'b1;
      @(posedge clk); #1; inval_all = 1'b0;
      do_acc(32'h00900010, 2'd0, 1'b1, 1'b0, 1'b1, 8'h05, 1'b1, 32'h0, 12'h040, 1'b0, 10);
      do_load(32'h00A00000, 8'h05, 32'h01000000, 2'd0, 2'b11, 1'b1, 1'b0);
      chk(10, "no flush after inval", {31'b0, flush_req}, 32'd0);

      // R6: wrap at a nonzero bound
      do_reset();
      wrap_bound = 6'd3;
      for (int k = 0; k < 5; k++) dummy();
      chk(6, "urc bound wrap", {26'b0, urc}, 32'd1);

      // R6: full range wrap with bound zero
      do_reset();
      wrap_bound = 6'd0;
      for (int k = 0; k < 63; k++) dummy();
      chk(6, "urc at 63", {26'b0, urc}, 32'd63);
      dummy();
      chk(6, "urc wrapped", {26'b0, urc}, 32'd0);

      finish_run();
   end

endmodule